// File: doc/BRIEF.md
# Multi-Line Transmit DMA Scheduler

This block moves outgoing bytes from memory to sixteen serial transmitters. Software first picks a line through a select field in the control register. It then writes that line's 18-bit start address and a byte count, given in two's-complement negative form, and sets the line's bit in a shared activity bitmap. A small scheduler serves the active lines in rotation. It fetches one byte per memory grant and parks the byte in a one-entry holding slot in front of the line's transmitter. The address and count registers step forward with every fetch. When a line's count reaches zero, its activity bit drops and a completion flag, which can raise an interrupt, is set.

Memory is reached through a request/grant read port. Read data and an error indication are valid in the grant cycle. A line that still has an undelivered byte is skipped until its transmitter takes that byte. Software can cut a running transfer short by loading a count of minus one, and can work out how many bytes went out by comparing the address register with the start address.

The scheduler has two states. SCH_IDLE moves to SCH_FETCH when some active line has an empty holding slot, latching the first such line after the last one served. Otherwise it stays in SCH_IDLE. SCH_FETCH holds the memory request until the grant arrives, then returns to SCH_IDLE.

Top module: `tdma_xmit_sched`

## Requirements
- R1: After reset, all four registers read 0, `irq` and `mem_req` are 0, and no `tx_valid` bit is set.
- R2: The register offsets on `reg_sel` are 0 = control, 1 = address (low 16 bits), 2 = count, 3 = active bitmap. Control bits 3:0 select the line whose address and count registers are read and written. A control write also loads control bits 5:4 into address bits 17:16 of the newly selected line, and a control read returns them in the same place.
- R3: Each fetch reads memory at the line's full 18-bit address. The byte appears on that line's `tx_data` slice, and the address then advances by one, with the carry passing from bit 15 into bit 16.
- R4: A count loaded as minus n yields exactly n fetched bytes. The count then reads 0 and the line's bit in the active bitmap (bit i for line i) clears.
- R5: Writing the active bitmap only sets bits. A 0 written to a bit leaves it unchanged.
- R6: Completion sets control bit 15, and `irq` equals bit 15 AND enable bit 13. A control write with bit 15 at 0 clears the flag, and one with bit 15 at 1 leaves it unchanged.
- R7: Eligible lines are served in rotation, starting after the last line served (line 0 first after reset), with one byte per grant.
- R8: A line whose byte is still held is not fetched again. `tx_valid` and `tx_data` stay fixed until `tx_ready`.
- R9: Loading a count of minus one into a line that has a held byte produces exactly one more byte, after which the line completes.
- R10: A grant with `mem_err` sets control bit 10, drops the line's active bit, delivers no byte, leaves the address and count unchanged, and does not set bit 15. A control write with bit 8 at 1 clears bit 10, and one with bit 8 at 0 does not.
- R11: `mem_req` stays high with a constant `mem_addr` until `mem_gnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq | output | 1 | Completion interrupt |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 18 | Memory read address |
| mem_gnt | input | 1 | Memory grant; data valid this cycle |
| mem_rdata | input | 8 | Memory read byte |
| mem_err | input | 1 | Memory read error, valid with grant |
| tx_valid | output | 16 | Per-line byte held for transmitter |
| tx_data | output | 128 | Per-line held byte, line i at bits 8i+7:8i |
| tx_ready | input | 16 | Per-line transmitter accepts byte |

## Verification
A register write at a clock edge is visible in `reg_rdata` from that edge onward. The bench therefore drives on falling edges and reads one cycle later. A fetch takes one SCH_IDLE cycle and at least one SCH_FETCH cycle, and the byte shows up on `tx_valid` the edge after the grant. For this reason completion, error and backpressure results are judged only after the bench has polled the active bitmap until the relevant bits drop, or after a fixed settling window much longer than a single fetch. Each byte is checked at the edge where its transmitter accepts it, against a memory pattern computed from the expected address.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
    localparam int REG_W = 16;

    localparam logic [1:0] OFS_CTRL = 2'd0;
    localparam logic [1:0] OFS_ADDR = 2'd1;
    localparam logic [1:0] OFS_CNT  = 2'd2;
    localparam logic [1:0] OFS_ACT  = 2'd3;

    localparam int CB_HI     = 4;
    localparam int CB_ERRCLR = 8;
    localparam int CB_ERR    = 10;
    localparam int CB_IEN    = 13;
    localparam int CB_DONE   = 15;

    typedef enum logic {
        SCH_IDLE  = 1'b0,
        SCH_FETCH = 1'b1
    } sch_state_e;
endpackage

// File: rtl/tdma_rr_pick.sv
module tdma_rr_pick #(
    parameter int N    = 16,
    parameter int IDXW = $clog2(N)
) (
    input  logic [N-1:0]    req,
    input  logic [IDXW-1:0] last,
    output logic            any,
    output logic [IDXW-1:0] pick
);
    logic [IDXW-1:0] cand;

    // Scan from the farthest offset down so the nearest one after 'last' wins.
    always_comb begin
        any  = 1'b0;
        pick = last;
        cand = '0;
        for (int off = N; off >= 1; off--) begin
            cand = last + IDXW'(off);
            if (req[cand]) begin
                any  = 1'b1;
                pick = cand;
            end
        end
    end
endmodule

// File: rtl/tdma_line.sv
module tdma_line
    import tdma_pkg::*;
#(
    parameter int HIW = 2,
    parameter int AW  = REG_W + HIW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lo_we,
    input  logic             hi_we,
    input  logic             cnt_we,
    input  logic [REG_W-1:0] wdata,
    input  logic [HIW-1:0]   hi_wdata,
    input  logic             fetch_ok,
    input  logic [7:0]       fetch_byte,
    input  logic             tx_ready,
    output logic [AW-1:0]    cur_addr,
    output logic [REG_W-1:0] cnt_eff,
    output logic [REG_W-1:0] cnt_q,
    output logic             tx_valid,
    output logic [7:0]       tx_data
);
    logic [AW-1:0] base_addr;

    always_comb begin
        base_addr = cur_addr;
        if (hi_we) base_addr[AW-1 -: HIW] = hi_wdata;
        if (lo_we) base_addr[REG_W-1:0]   = wdata;
        cnt_eff = cnt_we ? wdata : cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            cnt_q    <= '0;
        end else begin
            cur_addr <= fetch_ok ? base_addr + AW'(1) : base_addr;
            cnt_q    <= fetch_ok ? cnt_eff + REG_W'(1) : cnt_eff;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else if (fetch_ok) begin
            tx_valid <= 1'b1;
            tx_data  <= fetch_byte;
        end else if (tx_valid && tx_ready) begin
            tx_valid <= 1'b0;
        end
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R8
    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_ok |-> !tx_valid); // R8
endmodule

// File: rtl/tdma_sched_fsm.sv
module tdma_sched_fsm
    import tdma_pkg::*;
#(
    parameter int N    = 16,
    parameter int IDXW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    elig,
    input  logic            mem_gnt,
    output logic            mem_req,
    output logic            fire,
    output logic [IDXW-1:0] cur_line
);
    sch_state_e      state_q, state_d;
    logic            any;
    logic [IDXW-1:0] pick;

    tdma_rr_pick #(.N(N), .IDXW(IDXW)) u_pick (
        .req  (elig),
        .last (cur_line),
        .any  (any),
        .pick (pick)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCH_IDLE:  if (any)     state_d = SCH_FETCH;
            SCH_FETCH: if (mem_gnt) state_d = SCH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= SCH_IDLE;
            cur_line <= IDXW'(N - 1);
        end else begin
            state_q <= state_d;
            if (state_q == SCH_IDLE && any) cur_line <= pick;
        end
    end

    always_comb begin
        mem_req = (state_q == SCH_FETCH);
        fire    = (state_q == SCH_FETCH) && mem_gnt;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(cur_line)); // R11
endmodule

// File: rtl/tdma_xmit_sched.sv
module tdma_xmit_sched
    import tdma_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int ADDR_HI_W = 2,
    localparam int IDXW     = $clog2(NUM_LINES),
    localparam int AW       = REG_W + ADDR_HI_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_we,
    input  logic [1:0]             reg_sel,
    input  logic [15:0]            reg_wdata,
    output logic [15:0]            reg_rdata,
    output logic                   irq,
    output logic                   mem_req,
    output logic [AW-1:0]          mem_addr,
    input  logic                   mem_gnt,
    input  logic [7:0]             mem_rdata,
    input  logic                   mem_err,
    output logic [NUM_LINES-1:0]   tx_valid,
    output logic [NUM_LINES*8-1:0] tx_data,
    input  logic [NUM_LINES-1:0]   tx_ready
);
    logic [IDXW-1:0]      sel_q;
    logic                 ien_q, done_q, err_q;
    logic [NUM_LINES-1:0] act_q, clr_mask, set_mask, fetch_ok, elig;
    logic [AW-1:0]        line_addr    [NUM_LINES];
    logic [REG_W-1:0]     line_cnt     [NUM_LINES];
    logic [REG_W-1:0]     line_cnt_eff [NUM_LINES];
    logic                 ctrl_we, addr_we, cnt_we, act_we;
    logic                 fire, last, abort;
    logic [IDXW-1:0]      cur_line;
    logic [15:0]          ctrl_rd;

    always_comb begin
        ctrl_we = reg_we && reg_sel == OFS_CTRL;
        addr_we = reg_we && reg_sel == OFS_ADDR;
        cnt_we  = reg_we && reg_sel == OFS_CNT;
        act_we  = reg_we && reg_sel == OFS_ACT;
    end

    assign elig = act_q & ~tx_valid;

    tdma_sched_fsm #(.N(NUM_LINES), .IDXW(IDXW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .elig     (elig),
        .mem_gnt  (mem_gnt),
        .mem_req  (mem_req),
        .fire     (fire),
        .cur_line (cur_line)
    );

    assign mem_addr = line_addr[cur_line];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        assign fetch_ok[g] = fire && !mem_err && cur_line == IDXW'(g);

        tdma_line #(.HIW(ADDR_HI_W)) u_line (
            .clk        (clk),
            .rst_n      (rst_n),
            .lo_we      (addr_we && sel_q == IDXW'(g)),
            .hi_we      (ctrl_we && reg_wdata[IDXW-1:0] == IDXW'(g)),
            .cnt_we     (cnt_we && sel_q == IDXW'(g)),
            .wdata      (reg_wdata),
            .hi_wdata   (reg_wdata[CB_HI +: ADDR_HI_W]),
            .fetch_ok   (fetch_ok[g]),
            .fetch_byte (mem_rdata),
            .tx_ready   (tx_ready[g]),
            .cur_addr   (line_addr[g]),
            .cnt_eff    (line_cnt_eff[g]),
            .cnt_q      (line_cnt[g]),
            .tx_valid   (tx_valid[g]),
            .tx_data    (tx_data[g*8 +: 8])
        );
    end

    always_comb begin
        last     = fire && !mem_err && line_cnt_eff[cur_line] == {REG_W{1'b1}};
        abort    = fire && mem_err;
        clr_mask = (last || abort) ? (NUM_LINES'(1) << cur_line) : '0;
        set_mask = act_we ? reg_wdata[NUM_LINES-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q  <= '0;
            sel_q  <= '0;
            ien_q  <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            act_q <= (act_q & ~clr_mask) | set_mask;
            if (ctrl_we) begin
                sel_q <= reg_wdata[IDXW-1:0];
                ien_q <= reg_wdata[CB_IEN];
            end
            if (last)                               done_q <= 1'b1;
            else if (ctrl_we && !reg_wdata[CB_DONE]) done_q <= 1'b0;
            if (abort)                               err_q <= 1'b1;
            else if (ctrl_we && reg_wdata[CB_ERRCLR]) err_q <= 1'b0;
        end
    end

    always_comb begin
        ctrl_rd                       = '0;
        ctrl_rd[IDXW-1:0]             = sel_q;
        ctrl_rd[CB_HI +: ADDR_HI_W]   = line_addr[sel_q][AW-1 -: ADDR_HI_W];
        ctrl_rd[CB_ERR]               = err_q;
        ctrl_rd[CB_IEN]               = ien_q;
        ctrl_rd[CB_DONE]              = done_q;
        unique case (reg_sel)
            OFS_CTRL: reg_rdata = ctrl_rd;
            OFS_ADDR: reg_rdata = line_addr[sel_q][REG_W-1:0];
            OFS_CNT:  reg_rdata = line_cnt[sel_q];
            OFS_ACT:  reg_rdata = 16'(act_q);
        endcase
    end

    assign irq = done_q & ien_q;

    AST_FETCH_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> act_q[cur_line]); // R7
    AST_ERR_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        fire && mem_err |=> !tx_valid[$past(cur_line)]); // R10
    AST_LAST_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !mem_err && line_cnt_eff[cur_line] == {REG_W{1'b1}} && !act_we
        |=> !act_q[$past(cur_line)]); // R4
endmodule

// File: tb/tdma_xmit_sched_tb_top.sv
module tdma_xmit_sched_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [1:0]   reg_sel = 2'd0;
    logic [15:0]  reg_wdata = '0;
    logic [15:0]  reg_rdata;
    logic         irq, mem_req, mem_gnt, mem_err;
    logic [17:0]  mem_addr;
    logic [7:0]   mem_rdata;
    logic [15:0]  tx_valid;
    logic [127:0] tx_data;
    logic [15:0]  tx_ready = '1;
    logic         gnt_en = 1'b1;
    logic         err_en = 1'b0;
    logic [17:0]  err_addr = '0;

    int tests = 0, fails = 0;
    int mon_checks = 0, mon_fails = 0;
    int got [16];
    int ord [64];
    int ord_n = 0;
    logic [17:0] base [16];
    bit finished = 1'b0;

    always #2 clk = ~clk;

    function automatic logic [7:0] mdata(logic [17:0] a);
        return a[7:0] ^ a[15:8] ^ {6'b0, a[17:16]};
    endfunction

    assign mem_gnt   = mem_req & gnt_en;
    assign mem_rdata = mdata(mem_addr);
    assign mem_err   = err_en && mem_addr == err_addr;

    tdma_xmit_sched dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata), .mem_err(mem_err), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready)
    );

    // Byte monitor: R3 data check at each accepted byte
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) got[i] = 0;
            ord_n = 0;
        end else begin
            for (int i = 0; i < 16; i++) begin
                if (tx_valid[i] && tx_ready[i]) begin
                    mon_checks++;
                    if (tx_data[i*8 +: 8] !== mdata(base[i] + 18'(got[i]))) begin
                        mon_fails++;
                        $display("FAIL R3 line %0d byte %0d: got 0x%0h expected 0x%0h",
                                 i, got[i], tx_data[i*8 +: 8], mdata(base[i] + 18'(got[i])));
                    end
                    got[i]++;
                    if (ord_n < 64) ord[ord_n] = i;
                    ord_n++;
                end
            end
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] s, logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] s, output logic [15:0] d);
        @(negedge clk);
        reg_sel = s;
        #1 d = reg_rdata;
    endtask

    function automatic logic [15:0] cw(int line, logic [1:0] hi, bit ien, bit keep, bit eclr);
        logic [15:0] w = '0;
        w[3:0] = 4'(line); w[5:4] = hi; w[13] = ien; w[15] = keep; w[8] = eclr;
        return w;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tx_ready = '1; gnt_en = 1'b1; err_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic setup(int line, logic [17:0] start, int n, bit ien);
        base[line] = start;
        wr(0, cw(line, start[17:16], ien, 1'b1, 1'b0));
        wr(1, start[15:0]);
        wr(2, 16'(-n));
    endtask

    task automatic wait_clear(logic [15:0] mask, string req);
        logic [15:0] v;
        int k = 0;
        rd(3, v);
        while ((v & mask) != 0 && k < 5000) begin rd(3, v); k++; end
        chk(req, "active bits drain", 32'(v & mask), 32'h0);
        repeat (4) @(negedge clk);
    endtask

    task automatic line_regs(int line, bit ien, output logic [15:0] a, output logic [15:0] c);
        wr(0, cw(line, 2'b00, ien, 1'b1, 1'b0));
        rd(1, a);
        rd(2, c);
    endtask

    initial begin
        logic [15:0] v, a, c;
        logic [17:0] st;
        for (int i = 0; i < 16; i++) base[i] = '0;
        do_reset();

        // R1 reset state
        for (int r = 0; r < 4; r++) begin rd(2'(r), v); chk("R1", "register after reset", 32'(v), 32'h0); end
        chk("R1", "irq", 32'(irq), 0);
        chk("R1", "mem_req", 32'(mem_req), 0);
        chk("R1", "tx_valid", 32'(tx_valid), 0);

        // R2 register access through line select
        wr(0, cw(5, 2'b10, 1'b0, 1'b1, 1'b0));
        wr(1, 16'h1234); wr(2, 16'hFFF0);
        wr(0, cw(6, 2'b01, 1'b0, 1'b1, 1'b0));
        wr(1, 16'h5555);
        rd(0, v); chk("R2", "ctrl select 6", 32'(v), 32'h0016);
        rd(1, v); chk("R2", "line 6 address", 32'(v), 32'h5555);
        rd(2, v); chk("R2", "line 6 count", 32'(v), 32'h0);
        wr(0, cw(5, 2'b10, 1'b0, 1'b1, 1'b0));
        rd(0, v); chk("R2", "ctrl select 5", 32'(v), 32'h0025);
        rd(1, v); chk("R2", "line 5 address", 32'(v), 32'h1234);
        rd(2, v); chk("R2", "line 5 count", 32'(v), 32'hFFF0);
        rd(3, v); chk("R2", "nothing active", 32'(v), 32'h0);

        // R3 R4 R6 sweep over all lines, lengths 1..16
        do_reset();
        for (int i = 0; i < 16; i++) begin
            st = (i == 3) ? 18'h0FFFE : 18'(i * 32'h2345 + 32'h0FFD);
            setup(i, st, i + 1, 1'b1);
        end
        wr(3, 16'hFFFF);
        wait_clear(16'hFFFF, "R4");
        for (int i = 0; i < 16; i++) begin
            chk("R4", $sformatf("bytes on line %0d", i), 32'(got[i]), 32'(i + 1));
            line_regs(i, 1'b1, a, c);
            st = base[i] + 18'(i + 1);
            chk("R3", $sformatf("end address line %0d", i), 32'(a), 32'(st[15:0]));
            chk("R4", $sformatf("end count line %0d", i), 32'(c), 32'h0);
        end
        rd(0, v); chk("R6", "done flag", 32'(v[15]), 1);
        chk("R6", "irq with enable", 32'(irq), 1);
        wr(0, cw(0, 2'b00, 1'b1, 1'b1, 1'b0));
        rd(0, v); chk("R6", "write 1 keeps done", 32'(v[15]), 1);
        wr(0, cw(0, 2'b00, 1'b1, 1'b0, 1'b0));
        rd(0, v); chk("R6", "write 0 clears done", 32'(v[15]), 0);
        chk("R6", "irq after clear", 32'(irq), 0);

        // R7 rotation order
        do_reset();
        setup(9, 18'h00100, 2, 1'b0);
        setup(2, 18'h00200, 2, 1'b0);
        setup(5, 18'h00300, 2, 1'b0);
        wr(3, 16'h0224);
        wait_clear(16'h0224, "R7");
        chk("R7", "byte total", 32'(ord_n), 6);
        for (int k = 0; k < 6; k++) begin
            int e;
            e = (k % 3 == 0) ? 2 : ((k % 3 == 1) ? 5 : 9);
            chk("R7", $sformatf("service slot %0d", k), 32'(ord[k]), 32'(e));
        end
        rd(0, v); chk("R6", "done set without enable", 32'(v[15]), 1);
        chk("R6", "irq masked", 32'(irq), 0);

        // R8 backpressure, R5 zero write ignored, R9 stop
        do_reset();
        tx_ready[4] = 1'b0;
        setup(4, 18'h00300, 100, 1'b0);
        setup(8, 18'h20400, 3, 1'b0);
        wr(3, 16'h0110);
        repeat (60) @(negedge clk);
        chk("R8", "line 4 byte held", 32'(tx_valid[4]), 1);
        chk("R8", "line 8 unaffected", 32'(got[8]), 3);
        line_regs(4, 1'b0, a, c);
        chk("R8", "line 4 one fetch", 32'(a), 32'h0301);
        chk("R8", "line 4 count", 32'(c), 32'hFF9D);
        wr(3, 16'h0000);
        rd(3, v); chk("R5", "zero write keeps bit 4", 32'(v), 32'h0010);
        wr(2, 16'hFFFF);
        @(negedge clk); tx_ready[4] = 1'b1;
        wait_clear(16'h0010, "R9");
        chk("R9", "bytes after stop", 32'(got[4]), 2);
        line_regs(4, 1'b0, a, c);
        chk("R9", "address after stop", 32'(a), 32'h0302);
        chk("R9", "count after stop", 32'(c), 32'h0);

        // R10 memory error
        do_reset();
        err_addr = 18'h02002; err_en = 1'b1;
        setup(7, 18'h02000, 4, 1'b1);
        wr(3, 16'h0080);
        wait_clear(16'h0080, "R10");
        chk("R10", "bytes before error", 32'(got[7]), 2);
        line_regs(7, 1'b1, a, c);
        chk("R10", "address held", 32'(a), 32'h2002);
        chk("R10", "count held", 32'(c), 32'hFFFE);
        rd(0, v);
        chk("R10", "error flag", 32'(v[10]), 1);
        chk("R10", "no done", 32'(v[15]), 0);
        chk("R10", "no irq", 32'(irq), 0);
        err_en = 1'b0;
        wr(0, cw(7, 2'b00, 1'b1, 1'b1, 1'b0));
        rd(0, v); chk("R10", "bit 8 zero keeps error", 32'(v[10]), 1);
        wr(0, cw(7, 2'b00, 1'b1, 1'b1, 1'b1));
        rd(0, v); chk("R10", "bit 8 one clears error", 32'(v[10]), 0);

        // R11 request held without grant
        do_reset();
        gnt_en = 1'b0;
        setup(1, 18'h10040, 1, 1'b0);
        wr(3, 16'h0002);
        repeat (5) @(negedge clk);
        chk("R11", "request held", 32'(mem_req), 1);
        chk("R11", "address held", 32'(mem_addr), 32'h10040);
        chk("R11", "no byte yet", 32'(tx_valid[1]), 0);
        gnt_en = 1'b1;
        wait_clear(16'h0002, "R11");
        chk("R11", "byte after grant", 32'(got[1]), 1);

        tests += mon_checks;
        fails += mon_fails;
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests + mon_checks, fails + mon_fails);
            $finish;
        end
    end
endmodule